// File: doc/BRIEF.md
# Lane-masked carry-save reduction tree

This block compresses a fixed number of equal-width operand words into a redundant pair of words, a sum vector and a carry vector. Their ordinary sum equals the total of all operands. The tree is built from levels of word-wide 3:2 compressor rows. At each level the terms are taken in groups of three and each group is turned into two. Terms left over at a level pass to the next level untouched. Reduction stops when two terms remain.

The datapath is split into `LANES` equal slots. A runtime enable for each internal slot boundary decides whether that boundary separates two independent lanes. Every compressor carry is moved up one bit and then gated by a keep mask. The mask is cleared at each enabled boundary, so no carry ever crosses into the next lane. This lets several narrow SIMD sums share one tree, or lets the whole width act as one wide sum.

A parameter bit vector selects the levels that have a pipeline register at their output. The boundary enables and the valid strobe pass through the same registers as the data, so each result always carries the lane layout it was computed with. The final carry-propagate addition is done by a neighbouring block and is not part of this one.

Top module: `lane_csa_tree`

## Requirements
- R1: Take a lane as the bits between consecutive active boundaries. Boundary k (1 <= k < LANES) sits at bit k*W/LANES and is active when `part_en[k-1]` is 1. For every lane, the lane slice of `out_sum` plus the lane slice of `out_cry`, reduced modulo 2^(lane width), equals the sum of that slice of all `N_OPS` operands modulo 2^(lane width).
- R2: With `part_en` all zero the block acts as a single lane: (`out_sum` + `out_cry`) mod 2^W equals the sum of all operands mod 2^W.
- R3: `part_en[LANES-1]` has no effect: two inputs that differ only in that bit give identical `out_sum` and `out_cry`.
- R4: `out_cry` bit 0 is always 0. `out_cry` bit k*W/LANES is 0 whenever boundary k is active for the result shown.
- R5: `out_vld` repeats `in_vld` delayed by exactly the number of set bits of `REG_SEL` below the tree depth. With `REG_SEL=5` and `N_OPS=6` that delay is 2 cycles.
- R6: The boundary enables are pipelined together with their operands: back-to-back inputs with a different `part_en` each cycle each produce a result split by their own enables.
- R7: While `rst_n` is low, `out_vld` is 0 and every pipeline register holds 0, so a registered output reads `out_sum` = `out_cry` = 0.
- R8: With `REG_SEL=0` the block is purely combinational: the outputs match the current inputs in the same cycle, and `out_vld` equals `in_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional pipeline registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operand set valid |
| in_ops | input | N_OPS*W | Operands packed, operand i in bits [i*W +: W] |
| part_en | input | LANES | Boundary enables; bit k-1 activates the boundary at bit k*W/LANES; top bit ignored |
| out_vld | output | 1 | Result valid |
| out_sum | output | W | Redundant sum word |
| out_cry | output | W | Redundant carry word, already aligned to its weight |

## Verification
The bench builds two copies of the block. The first uses W=32, six operands, four slots and `REG_SEL=5`. That gives a depth of three levels with registers after the first and the last. It exposes the two-cycle latency, a level that passes a leftover term through, and lane widths of 8, 16, 24 and 32 bits mixed within one word. The second uses W=16, seven operands, eight 2-bit slots and no registers. It reaches a four-level combinational tree, odd leftover counts at several levels, and the narrowest lanes, where carries are dropped most often.

// File: rtl/lcsa_pkg.sv
package lcsa_pkg;

   // Number of terms after one level of 3:2 grouping.
   function automatic int next_terms(input int n);
      return (n / 3) * 2 + (n % 3);
   endfunction

   // Terms present at the input of level lvl.
   function automatic int terms_at(input int n, input int lvl);
      int t;
      t = n;
      for (int i = 0; i < lvl; i++) t = next_terms(t);
      return t;
   endfunction

   // Levels needed to come down to two terms.
   function automatic int tree_depth(input int n);
      int t;
      int d;
      t = n;
      d = 0;
      while (t > 2) begin
         t = next_terms(t);
         d++;
      end
      return d;
   endfunction

   // Registered levels below a given depth.
   function automatic int reg_count(input logic [31:0] sel, input int depth);
      int c;
      c = 0;
      for (int i = 0; i < depth; i++) if (sel[i]) c++;
      return c;
   endfunction

endpackage

// File: rtl/lcsa_keep_mask.sv
module lcsa_keep_mask #(
   parameter int W     = 32,
   parameter int LANES = 4
) (
   input  logic [LANES-1:0] bnd_en,
   output logic [W-1:0]     keep
);
   localparam int LW = W / LANES;

   // The top enable names no boundary inside the word.
   logic unused_top_en;
   assign unused_top_en = bnd_en[LANES-1];

   for (genvar b = 0; b < W; b++) begin : g_bit
      if ((b != 0) && (b % LW == 0)) begin : g_bnd
         assign keep[b] = ~bnd_en[b / LW - 1];
      end else begin : g_free
         assign keep[b] = 1'b1;
      end
   end
endmodule

// File: rtl/lcsa_row.sv
module lcsa_row #(
   parameter int W = 32
) (
   input  logic [W-1:0] in_a,
   input  logic [W-1:0] in_b,
   input  logic [W-1:0] in_c,
   input  logic [W-1:0] keep,
   output logic [W-1:0] out_sum,
   output logic [W-1:0] out_cry
);
   logic [W-1:0] maj;
   logic         unused_msb_cry;

   assign out_sum        = in_a ^ in_b ^ in_c;
   assign maj            = (in_a & in_b) | (in_a & in_c) | (in_b & in_c);
   // shift first, then gate: one and-or-invert stage per bit
   assign out_cry        = {maj[W-2:0], 1'b0} & keep;
   assign unused_msb_cry = maj[W-1];

   // R2: with no boundary active the row preserves the modular total
   logic [W-1:0] tot_in;
   logic [W-1:0] tot_out;
   assign tot_in  = in_a + in_b + in_c;
   assign tot_out = out_sum + out_cry;
   always_comb begin
      if (!$isunknown({in_a, in_b, in_c, keep}) && (&keep)) begin
         a_r2_row_conserves: assert (tot_in == tot_out);
      end
   end
endmodule

// File: rtl/lcsa_level.sv
module lcsa_level #(
   parameter int W     = 32,
   parameter int LANES = 4,
   parameter int TW    = 192,
   parameter int N_IN  = 6,
   parameter int N_OUT = 4,
   parameter bit REG   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TW-1:0]    in_terms,
   input  logic [LANES-1:0] in_en,
   input  logic             in_vld,
   output logic [TW-1:0]    out_terms,
   output logic [LANES-1:0] out_en,
   output logic             out_vld
);
   localparam int G   = N_IN / 3;
   localparam int REM = N_IN - 3 * G;

   if (N_OUT != 2 * G + REM) begin : g_bad_count
      $error("lcsa_level: N_OUT does not follow from N_IN");
   end
   if (G < 1) begin : g_bad_group
      $error("lcsa_level: fewer than three inputs");
   end

   logic [W-1:0]       keep;
   logic [N_OUT*W-1:0] nxt;

   lcsa_keep_mask #(.W(W), .LANES(LANES)) u_mask (
      .bnd_en (in_en),
      .keep   (keep)
   );

   for (genvar g = 0; g < G; g++) begin : g_row
      lcsa_row #(.W(W)) u_row (
         .in_a    (in_terms[(3*g)*W   +: W]),
         .in_b    (in_terms[(3*g+1)*W +: W]),
         .in_c    (in_terms[(3*g+2)*W +: W]),
         .keep    (keep),
         .out_sum (nxt[(2*g)*W   +: W]),
         .out_cry (nxt[(2*g+1)*W +: W])
      );
   end

   for (genvar r = 0; r < REM; r++) begin : g_pass
      assign nxt[(2*G+r)*W +: W] = in_terms[(3*G+r)*W +: W];
   end

   if (N_IN * W < TW) begin : g_in_tail
      logic unused_in_tail;
      assign unused_in_tail = ^in_terms[TW-1:N_IN*W];
   end

   logic [N_OUT*W-1:0] stage_q;

   if (REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q <= '0;
            out_en  <= '0;
            out_vld <= 1'b0;
         end else begin
            stage_q <= nxt;
            out_en  <= in_en;
            out_vld <= in_vld;
         end
      end

      // R5: a registered level delays the valid by exactly one cycle
      a_r5_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld |=> out_vld);
      a_r5_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
         !in_vld |=> !out_vld);
      // R6: lane enables move with their operands
      a_r6_en_follow: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (out_en == $past(in_en)));
   end else begin : g_comb
      assign stage_q = nxt;
      assign out_en  = in_en;
      assign out_vld = in_vld;
   end

   assign out_terms[N_OUT*W-1:0] = stage_q;
   if (N_OUT * W < TW) begin : g_out_tail
      assign out_terms[TW-1:N_OUT*W] = '0;
   end
endmodule

// File: rtl/lane_csa_tree.sv
module lane_csa_tree #(
   parameter int          W       = 32,
   parameter int          N_OPS   = 6,
   parameter int          LANES   = 4,
   parameter logic [31:0] REG_SEL = 32'h5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_vld,
   input  logic [N_OPS*W-1:0] in_ops,
   input  logic [LANES-1:0]   part_en,
   output logic               out_vld,
   output logic [W-1:0]       out_sum,
   output logic [W-1:0]       out_cry
);
   import lcsa_pkg::*;

   localparam int TW    = N_OPS * W;
   localparam int DEPTH = tree_depth(N_OPS);
   localparam int LW    = W / LANES;
   localparam int LAT   = reg_count(REG_SEL, DEPTH);

   if (N_OPS < 3 || N_OPS > 64) begin : g_bad_nops
      $error("lane_csa_tree: N_OPS must be within 3..64");
   end
   if (LANES < 1 || (W % LANES) != 0) begin : g_bad_lanes
      $error("lane_csa_tree: W must divide evenly into LANES slots");
   end
   if (W < 2) begin : g_bad_w
      $error("lane_csa_tree: W must be at least 2");
   end
   if ((REG_SEL >> DEPTH) != 32'd0) begin : g_bad_sel
      $error("lane_csa_tree: REG_SEL names a level beyond the tree depth");
   end

   logic [TW-1:0]    stg_t [0:DEPTH];
   logic [LANES-1:0] stg_e [0:DEPTH];
   logic             stg_v [0:DEPTH];

   assign stg_t[0] = in_ops;
   assign stg_e[0] = part_en;
   assign stg_v[0] = in_vld;

   for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
      lcsa_level #(
         .W     (W),
         .LANES (LANES),
         .TW    (TW),
         .N_IN  (terms_at(N_OPS, l)),
         .N_OUT (terms_at(N_OPS, l + 1)),
         .REG   (REG_SEL[l])
      ) u_lvl (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_terms  (stg_t[l]),
         .in_en     (stg_e[l]),
         .in_vld    (stg_v[l]),
         .out_terms (stg_t[l+1]),
         .out_en    (stg_e[l+1]),
         .out_vld   (stg_v[l+1])
      );
   end

   assign out_sum = stg_t[DEPTH][W-1:0];
   assign out_cry = stg_t[DEPTH][2*W-1:W];
   assign out_vld = stg_v[DEPTH];

   logic unused_tail;
   assign unused_tail = ^stg_t[DEPTH][TW-1:2*W];

   // R4: weight-0 carry is never set
   a_r4_lsb_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> !out_cry[0]);

   // R4: no carry lands on an active boundary of the result's own layout
   for (genvar k = 1; k < LANES; k++) begin : g_bnd_chk
      a_r4_boundary_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (out_vld && stg_e[DEPTH][k-1]) |-> !out_cry[k*LW]);
   end

   // R8: with no registers selected the valid passes straight through
   if (LAT == 0) begin : g_comb_chk
      always_comb begin
         if (!$isunknown(in_vld)) begin
            a_r8_comb_valid: assert (out_vld == in_vld);
         end
      end
   end
endmodule

// File: tb/lane_csa_tree_tb_top.sv
`timescale 1ns/1ps
module lane_csa_tree_tb_top;
   localparam int W   = 32;
   localparam int N   = 6;
   localparam int L   = 4;
   localparam int LAT = 2;
   localparam int W2  = 16;
   localparam int N2  = 7;
   localparam int L2  = 8;
   localparam int NT  = 8;
   localparam int NV  = 48;

   // stimulus table: {part_en, op5 .. op0}
   localparam logic [4+6*32-1:0] TBL [NT] = '{
      {4'b0111, {6{32'hFFFF_FFFF}}},
      {4'b0000, {6{32'hFFFF_FFFF}}},
      {4'b0000, 32'd6, 32'd5, 32'd4, 32'd3, 32'd2, 32'd1},
      {4'b0101, {6{32'h00FF_00FF}}},
      {4'b1101, {6{32'h00FF_00FF}}},
      {4'b0111, {6{32'h8080_8080}}},
      {4'b1111, {6{32'h8080_8080}}},
      {4'b0111, {6{32'h0000_0000}}}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic            in_vld;
   logic [N*W-1:0]  in_ops;
   logic [L-1:0]    part_en;
   logic            out_vld;
   logic [W-1:0]    out_sum, out_cry;

   logic            c_vld;
   logic [N2*W2-1:0] c_ops;
   logic [L2-1:0]   c_en;
   logic            c_out_vld;
   logic [W2-1:0]   c_sum, c_cry;

   lane_csa_tree #(.W(W), .N_OPS(N), .LANES(L), .REG_SEL(32'h5)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_ops(in_ops),
      .part_en(part_en), .out_vld(out_vld), .out_sum(out_sum), .out_cry(out_cry));

   lane_csa_tree #(.W(W2), .N_OPS(N2), .LANES(L2), .REG_SEL(32'h0)) dut_comb_i (
      .clk(clk), .rst_n(rst_n), .in_vld(c_vld), .in_ops(c_ops),
      .part_en(c_en), .out_vld(c_out_vld), .out_sum(c_sum), .out_cry(c_cry));

   int checks = 0;
   int errors = 0;

   logic [31:0] op_v  [NV][7];
   logic [3:0]  en_v  [NV];
   logic [7:0]  en2_v [NV];
   logic        vld_v [NV];
   logic [31:0] got_s [NV];
   logic [31:0] got_c [NV];

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-lane modular sum check, lanes split at active boundaries
   task automatic chk_lanes(input logic [31:0] ops [7], input int n, input int w,
                            input int lanes, input logic [7:0] en,
                            input logic [31:0] s, input logic [31:0] c,
                            input string req);
      int lw, lo, hi;
      logic [63:0] m, e, a;
      lw = w / lanes;
      lo = 0;
      for (int k = 1; k <= lanes; k++) begin
         if (k == lanes || en[k-1]) begin
            hi = k * lw;
            m = (64'd1 << (hi - lo)) - 64'd1;
            e = 64'd0;
            for (int o = 0; o < n; o++) e = e + ((64'(ops[o]) >> lo) & m);
            e = e & m;
            a = (((64'(s) >> lo) & m) + ((64'(c) >> lo) & m)) & m;
            chk(a == e, req, a, e);
            if (en[k-1] && k < lanes)
               chk(c[hi] == 1'b0, "R4 boundary carry", 64'(c[hi]), 64'd0);
            lo = hi;
         end
      end
      chk(c[0] == 1'b0, "R4 lsb carry", 64'(c[0]), 64'd0);
   endtask

   task automatic drive(input int i);
      logic [31:0] ops [7];
      in_vld  = vld_v[i];
      part_en = en_v[i];
      for (int o = 0; o < N; o++) in_ops[o*W +: W] = op_v[i][o];
      c_vld = vld_v[i];
      c_en  = en2_v[i];
      for (int o = 0; o < N2; o++) c_ops[o*W2 +: W2] = op_v[i][o][15:0];
      #1;
      ops = op_v[i];
      chk(c_out_vld == vld_v[i], "R8 comb valid", 64'(c_out_vld), 64'(vld_v[i]));
      chk_lanes(ops, N2, W2, L2, en2_v[i], 32'(c_sum), 32'(c_cry), "R8/R1 comb lanes");
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog expired actual=hang expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] ops [7];
      int j;
      for (int i = 0; i < NV; i++) begin
         if (i < NT) begin
            en_v[i]  = TBL[i][4+6*32-1 -: 4];
            for (int o = 0; o < 6; o++) op_v[i][o] = TBL[i][o*32 +: 32];
            op_v[i][6] = TBL[i][31:0];
            en2_v[i] = {en_v[i], en_v[i]};
            vld_v[i] = 1'b1;
         end else begin
            for (int o = 0; o < 7; o++) op_v[i][o] = $urandom;
            en_v[i]  = 4'($urandom);
            en2_v[i] = 8'($urandom);
            vld_v[i] = (i % 5 != 3);
         end
      end
      in_vld = 1'b0; in_ops = '0; part_en = '0;
      c_vld = 1'b0; c_ops = '0; c_en = '0;

      // R7: reset state
      repeat (3) @(negedge clk);
      chk(out_vld == 1'b0, "R7 reset valid", 64'(out_vld), 64'd0);
      chk(out_sum == '0 && out_cry == '0, "R7 reset data",
          {out_sum, out_cry}, 64'd0);
      rst_n = 1'b1;

      // table then random stream, back to back with varying enables
      for (int i = 0; i < NV + LAT; i++) begin
         @(negedge clk);
         if (i < NV) drive(i);
         else begin
            in_vld = 1'b0; c_vld = 1'b0;
            #1;
         end
         j = i - LAT;
         if (j >= 0) begin
            chk(out_vld == vld_v[j], "R5 valid latency", 64'(out_vld), 64'(vld_v[j]));
            ops = op_v[j];
            got_s[j] = out_sum;
            got_c[j] = out_cry;
            if (en_v[j][2:0] == 3'b000)
               chk_lanes(ops, N, W, L, 8'(en_v[j]), out_sum, out_cry, "R2 single lane");
            else
               chk_lanes(ops, N, W, L, 8'(en_v[j]), out_sum, out_cry, "R1/R6 lane sums");
         end
      end

      // R3: top enable bit ignored
      chk(got_s[3] == got_s[4] && got_c[3] == got_c[4], "R3 top enable ignored",
          {got_s[4], got_c[4]}, {got_s[3], got_c[3]});
      chk(got_s[5] == got_s[6] && got_c[5] == got_c[6], "R3 top enable ignored",
          {got_s[6], got_c[6]}, {got_s[5], got_c[5]});

      // R7: reset in the middle of traffic
      @(negedge clk);
      drive(0);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(out_vld == 1'b0, "R7 mid-run reset valid", 64'(out_vld), 64'd0);
      chk(out_sum == '0 && out_cry == '0, "R7 mid-run reset data",
          {out_sum, out_cry}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      in_vld = 1'b0; c_vld = 1'b0;
      repeat (3) @(negedge clk);
      chk(out_vld == 1'b0, "R5 idle after reset", 64'(out_vld), 64'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule